// File: doc/BRIEF.md
# Instruction Cache Invalidation Sequencer

This block holds the control and status state that wipes the valid bits of a small two-way instruction cache tag store. A full wipe starts in one of two ways. Software can raise a one-shot launch strobe, or it can write zero to the enable bit while the cache is on. The sequencer then steps through every set index, one index per clock, and clears both ways of that set together. While a wipe is pending or running, the cache is bypassed, so every access is treated as uncached and no lookup reports a hit.

At the end of a wipe, the busy indication drops and a sticky completion flag rises. That flag stays set until software writes a one to its clear strobe. A separate error flag, set by an event from the datapath, has its own clear strobe and its own interrupt enable. Both flags, each gated by its enable, feed a single interrupt line.

The tag store is modelled in the block as register arrays. A simple fill port writes lines into it, and a lookup port reports a hit and the way that hit. The way selection is either direct-mapped or two-way, with two-way as the reset value, and it can be changed only while the cache reads back as disabled.

Top module: `icinv_ctrl`

## Requirements
- R1: A launch strobe accepted at clock edge k makes `busy` rise at edge k+1. `busy` then stays high for exactly SETS cycles.
- R2: Writing 0 to the enable bit while `en_rd` is 1 starts the same wipe. `en_rd` still reads 1 for one more cycle and falls at the edge where `busy` rises.
- R3: `bypass` is 1 whenever the cache is disabled, a wipe is pending, or `busy` is 1. While `bypass` is 1, `lookup_hit` is 0.
- R4: At the end of a wipe, `busyend` becomes 1 and stays 1 until a cycle with `clr_busyend` high. If a completion and a clear fall in the same cycle, the completion wins.
- R5: `irq` is 1 exactly when (`busyend` and `busyend_ie`) or (`err_flag` and `err_ie`) is true.
- R6: `err_event` sets `err_flag` at the next edge. The flag stays set until a cycle with `clr_err` high.
- R7: `assoc_rd` resets to 1 (two-way). A write on `assoc_wr` takes effect only when `en_rd` is 0.
- R8: In direct-mapped mode (`assoc_rd` = 0), fills always go to way 0 and only way 0 is looked up.
- R9: During a wipe, index i is cleared in both ways during the (i+1)-th busy cycle. After the wipe, no lookup hits until lines are filled again.
- R10: A launch strobe or disable write that arrives while `busy` is 1 or a start is pending cannot stretch the running sweep, and a launch strobe arriving then is discarded. `inv_rd` reads 1 from acceptance until the sweep starts, then clears by itself.
- R11: With `bypass` at 0, `lookup_hit` is 1 when an enabled way at `lookup_idx` is valid and holds `lookup_tag`. `hit_way` gives that way (0 or 1), and way 0 is preferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| en_rd | output | 1 | Enable readback; stays 1 until the disable wipe starts |
| inv_launch | input | 1 | One-shot request for a full wipe |
| inv_rd | output | 1 | Launch bit readback; self-clearing |
| assoc_wr | input | 1 | Write strobe for the way selection |
| assoc_wdata | input | 1 | 0 = direct-mapped, 1 = two-way |
| assoc_rd | output | 1 | Current way selection |
| busyend_ie | input | 1 | Interrupt enable for the completion flag |
| err_ie | input | 1 | Interrupt enable for the error flag |
| clr_busyend | input | 1 | Write-one-to-clear for the completion flag |
| clr_err | input | 1 | Write-one-to-clear for the error flag |
| err_event | input | 1 | Error event from the datapath |
| busy | output | 1 | Wipe in progress |
| busyend | output | 1 | Sticky wipe-complete flag |
| err_flag | output | 1 | Sticky error flag |
| irq | output | 1 | Combined interrupt |
| bypass | output | 1 | Tells the datapath to treat accesses as uncached |
| sweep_clr | output | 1 | Sweep clear strobe for the tag store |
| sweep_idx | output | IDX_W | Set index being cleared |
| fill_we | input | 1 | Fill write strobe |
| fill_idx | input | IDX_W | Fill set index |
| fill_way | input | 1 | Fill way (ignored when direct-mapped) |
| fill_tag | input | TAG_W | Fill tag |
| lookup_idx | input | IDX_W | Lookup set index |
| lookup_tag | input | TAG_W | Lookup tag |
| lookup_hit | output | 1 | Lookup hit |
| hit_way | output | 1 | Way that hit |

## Verification
The assertions check on every cycle the rules that hold cycle by cycle:
- bypass is high while busy, and no hit is reported under bypass;
- the completion flag is sticky and rises when a sweep ends;
- the sweep index steps by one;
- the interrupt agrees with the flag and enable pairs;
- the way selection cannot change while the cache reads as enabled;
- the enable readback falls only together with the start of a sweep.

Other behaviours show only at the ports over a whole scenario, so only the bench's scenarios can show them:
- the exact sweep length of SETS cycles;
- that a launch strobe during a sweep does not produce a second sweep;
- that every line misses after a wipe;
- the one-cycle delay before a disable takes effect;
- the fill redirection of direct-mapped mode.

// File: rtl/icinv_pkg.sv
package icinv_pkg;

  localparam int WAYS = 2;

  // Way selection encoding: 0 = direct-mapped, 1 = two-way.
  typedef enum logic {
    ASSOC_DIRECT = 1'b0,
    ASSOC_TWO    = 1'b1
  } assoc_e;

  // Ways that take part in lookups and fills for a given selection.
  function automatic logic [WAYS-1:0] way_mask(input logic assoc);
    return assoc ? 2'b11 : 2'b01;
  endfunction

  // Way a fill lands in; direct-mapped mode forces way 0.
  function automatic logic fill_target(input logic assoc, input logic req_way);
    return assoc & req_way;
  endfunction

  // True when the sweep sits on its final set index.
  function automatic logic idx_is_last(input int unsigned idx, input int unsigned sets);
    return idx == (sets - 1);
  endfunction

endpackage

// File: rtl/icinv_seq.sv
module icinv_seq #(
  parameter int SETS  = 8,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             inv_launch,
  output logic             en_q,
  output logic             inv_pend,
  output logic             dis_pend,
  output logic             busy,
  output logic [IDX_W-1:0] sweep_idx,
  output logic             sweep_done
);
  import icinv_pkg::*;

  logic start_now;
  logic launch_ok;

  assign start_now  = (inv_pend | dis_pend) & ~busy;
  assign launch_ok  = inv_launch & ~busy & ~inv_pend & ~dis_pend;
  assign sweep_done = busy & idx_is_last(int'(sweep_idx), SETS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      inv_pend  <= 1'b0;
      dis_pend  <= 1'b0;
      busy      <= 1'b0;
      sweep_idx <= '0;
    end else begin
      if (start_now) begin
        busy      <= 1'b1;
        sweep_idx <= '0;
        inv_pend  <= 1'b0;
        dis_pend  <= 1'b0;
        if (dis_pend) en_q <= 1'b0;
      end else if (busy) begin
        if (sweep_done) busy <= 1'b0;
        else            sweep_idx <= sweep_idx + 1'b1;
      end
      if (launch_ok) inv_pend <= 1'b1;
      if (en_wr && !dis_pend) begin
        if (en_wdata)  en_q     <= 1'b1;
        else if (en_q) dis_pend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/icinv_flags.sv
module icinv_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic sweep_done,
  input  logic clr_busyend,
  input  logic err_event,
  input  logic clr_err,
  input  logic busyend_ie,
  input  logic err_ie,
  output logic busyend,
  output logic err_flag,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyend  <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (sweep_done)       busyend <= 1'b1;
      else if (clr_busyend) busyend <= 1'b0;
      if (err_event)        err_flag <= 1'b1;
      else if (clr_err)     err_flag <= 1'b0;
    end
  end

  assign irq = (busyend & busyend_ie) | (err_flag & err_ie);

endmodule

// File: rtl/icinv_tags.sv
module icinv_tags #(
  parameter int SETS  = 8,
  parameter int TAG_W = 4,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             assoc,
  input  logic             bypass,
  input  logic             sweep_clr,
  input  logic [IDX_W-1:0] sweep_idx,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [IDX_W-1:0] lookup_idx,
  input  logic [TAG_W-1:0] lookup_tag,
  output logic             lookup_hit,
  output logic             hit_way
);
  import icinv_pkg::*;

  logic [WAYS-1:0] mask;
  logic [WAYS-1:0] match;
  logic            tgt_way;

  assign mask    = way_mask(assoc);
  assign tgt_way = fill_target(assoc, fill_way);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  valid;
    logic [TAG_W-1:0] tags [SETS];
    logic             wr_here;

    assign wr_here = fill_we & ~sweep_clr & (tgt_way == w[0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid <= '0;
        for (int s = 0; s < SETS; s++) tags[s] <= '0;
      end else if (sweep_clr) begin
        valid[sweep_idx] <= 1'b0;
      end else if (wr_here) begin
        valid[fill_idx] <= 1'b1;
        tags[fill_idx]  <= fill_tag;
      end
    end

    assign match[w] = mask[w] & valid[lookup_idx] & (tags[lookup_idx] == lookup_tag);
  end

  assign lookup_hit = ~bypass & (|match);
  assign hit_way    = ~match[0];

endmodule

// File: rtl/icinv_ctrl.sv
module icinv_ctrl #(
  parameter int SETS  = 8,
  parameter int TAG_W = 4,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_wdata,
  output logic             en_rd,
  input  logic             inv_launch,
  output logic             inv_rd,
  input  logic             assoc_wr,
  input  logic             assoc_wdata,
  output logic             assoc_rd,
  input  logic             busyend_ie,
  input  logic             err_ie,
  input  logic             clr_busyend,
  input  logic             clr_err,
  input  logic             err_event,
  output logic             busy,
  output logic             busyend,
  output logic             err_flag,
  output logic             irq,
  output logic             bypass,
  output logic             sweep_clr,
  output logic [IDX_W-1:0] sweep_idx,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [IDX_W-1:0] lookup_idx,
  input  logic [TAG_W-1:0] lookup_tag,
  output logic             lookup_hit,
  output logic             hit_way
);
  import icinv_pkg::*;

  logic en_q, inv_pend, dis_pend, sweep_done;
  logic assoc_q;

  icinv_seq #(.SETS(SETS), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .inv_launch (inv_launch),
    .en_q       (en_q),
    .inv_pend   (inv_pend),
    .dis_pend   (dis_pend),
    .busy       (busy),
    .sweep_idx  (sweep_idx),
    .sweep_done (sweep_done)
  );

  icinv_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .sweep_done  (sweep_done),
    .clr_busyend (clr_busyend),
    .err_event   (err_event),
    .clr_err     (clr_err),
    .busyend_ie  (busyend_ie),
    .err_ie      (err_ie),
    .busyend     (busyend),
    .err_flag    (err_flag),
    .irq         (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                assoc_q <= ASSOC_TWO;
    else if (assoc_wr && !en_q) assoc_q <= assoc_wdata;
  end

  assign en_rd     = en_q;
  assign inv_rd    = inv_pend;
  assign assoc_rd  = assoc_q;
  assign sweep_clr = busy;
  assign bypass    = ~en_q | busy | inv_pend | dis_pend;

  icinv_tags #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .assoc      (assoc_q),
    .bypass     (bypass),
    .sweep_clr  (sweep_clr),
    .sweep_idx  (sweep_idx),
    .fill_we    (fill_we),
    .fill_idx   (fill_idx),
    .fill_way   (fill_way),
    .fill_tag   (fill_tag),
    .lookup_idx (lookup_idx),
    .lookup_tag (lookup_tag),
    .lookup_hit (lookup_hit),
    .hit_way    (hit_way)
  );

endmodule

// File: rtl/icinv_chk.sv
module icinv_chk #(
  parameter int SETS  = 8,
  parameter int IDX_W = $clog2(SETS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_rd,
  input logic             inv_rd,
  input logic             assoc_rd,
  input logic             busyend_ie,
  input logic             err_ie,
  input logic             clr_busyend,
  input logic             err_event,
  input logic             busy,
  input logic             busyend,
  input logic             err_flag,
  input logic             irq,
  input logic             bypass,
  input logic             lookup_hit,
  input logic [IDX_W-1:0] sweep_idx,
  input logic             sweep_done
);

  AST_BUSY_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bypass); // R3
  AST_NO_HIT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> !lookup_hit); // R3
  AST_BUSYEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busyend && !clr_busyend) |=> busyend); // R4
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> (busyend && !busy)); // R4
  AST_IRQ_BUSYEND: assert property (@(posedge clk) disable iff (!rst_n)
    (busyend && busyend_ie) |-> irq); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busyend && !err_flag) |-> !irq); // R5
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> err_flag); // R6
  AST_ASSOC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    en_rd |=> $stable(assoc_rd)); // R7
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (sweep_idx == IDX_W'($past(sweep_idx) + 1'b1))); // R9
  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !inv_rd); // R10
  AST_EN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_rd) |-> $rose(busy)); // R2

endmodule

bind icinv_ctrl icinv_chk #(.SETS(SETS), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_rd       (en_rd),
  .inv_rd      (inv_rd),
  .assoc_rd    (assoc_rd),
  .busyend_ie  (busyend_ie),
  .err_ie      (err_ie),
  .clr_busyend (clr_busyend),
  .err_event   (err_event),
  .busy        (busy),
  .busyend     (busyend),
  .err_flag    (err_flag),
  .irq         (irq),
  .bypass      (bypass),
  .lookup_hit  (lookup_hit),
  .sweep_idx   (sweep_idx),
  .sweep_done  (sweep_done)
);

// File: tb/tb_icinv_ctrl.sv
module tb_icinv_ctrl;
  localparam int SETS       = 8;
  localparam int TAG_W      = 4;
  localparam int IDX_W      = 3;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic en_wr, en_wdata, en_rd, inv_launch, inv_rd;
  logic assoc_wr, assoc_wdata, assoc_rd;
  logic busyend_ie, err_ie, clr_busyend, clr_err, err_event;
  logic busy, busyend, err_flag, irq, bypass, sweep_clr;
  logic [IDX_W-1:0] sweep_idx, fill_idx, lookup_idx;
  logic fill_we, fill_way, lookup_hit, hit_way;
  logic [TAG_W-1:0] fill_tag, lookup_tag;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icinv_ctrl #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [TAG_W-1:0] tag_of(input int i, input int w);
    return TAG_W'((i * 3 + w * 5 + 1) % (1 << TAG_W));
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic fill(input int i, input int w, input logic [TAG_W-1:0] t);
    fill_we = 1'b1; fill_idx = IDX_W'(i); fill_way = w[0]; fill_tag = t;
    step();
    fill_we = 1'b0;
  endtask

  task automatic look(input int i, input logic [TAG_W-1:0] t);
    lookup_idx = IDX_W'(i); lookup_tag = t;
    #1;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy === 1'b1 && n < 100) begin
      n++;
      inv_launch = (n == 3);
      step();
    end
    inv_launch = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    int n;
    rst_n = 1'b0;
    en_wr = 0; en_wdata = 0; inv_launch = 0; assoc_wr = 0; assoc_wdata = 0;
    busyend_ie = 0; err_ie = 0; clr_busyend = 0; clr_err = 0; err_event = 0;
    fill_we = 0; fill_idx = '0; fill_way = 0; fill_tag = '0;
    lookup_idx = '0; lookup_tag = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // Reset state
    chk("R1", "busy after reset", busy, 0);
    chk("R4", "busyend after reset", busyend, 0);
    chk("R5", "irq after reset", irq, 0);
    chk("R2", "en_rd after reset", en_rd, 0);
    chk("R7", "assoc_rd after reset", assoc_rd, 1);
    chk("R3", "bypass while disabled", bypass, 1);

    // Enable
    en_wr = 1; en_wdata = 1; step(); en_wr = 0;
    chk("R2", "en_rd after enable", en_rd, 1);
    chk("R3", "bypass when enabled idle", bypass, 0);

    // Exhaustive fill and lookup, two-way mode
    for (int i = 0; i < SETS; i++)
      for (int w = 0; w < 2; w++) fill(i, w, tag_of(i, w));
    for (int i = 0; i < SETS; i++) begin
      for (int w = 0; w < 2; w++) begin
        look(i, tag_of(i, w));
        chk("R11", $sformatf("hit idx%0d way%0d", i, w), lookup_hit, 1);
        chk("R11", $sformatf("hit_way idx%0d", i), hit_way, w);
      end
      for (int t = 0; t < (1 << TAG_W); t++) begin
        if (TAG_W'(t) != tag_of(i, 0) && TAG_W'(t) != tag_of(i, 1)) begin
          look(i, TAG_W'(t));
          chk("R11", $sformatf("miss idx%0d tag%0d", i, t), lookup_hit, 0);
          break;
        end
      end
    end

    // Way selection locked while enabled
    assoc_wr = 1; assoc_wdata = 0; step(); assoc_wr = 0;
    chk("R7", "assoc write ignored while enabled", assoc_rd, 1);

    // Error flag and interrupt
    err_event = 1; step(); err_event = 0;
    chk("R6", "err_flag set", err_flag, 1);
    chk("R5", "irq masked error", irq, 0);
    err_ie = 1; #1;
    chk("R5", "irq from error", irq, 1);
    step();
    chk("R6", "err_flag sticky", err_flag, 1);
    clr_err = 1; step(); clr_err = 0;
    chk("R6", "err_flag cleared", err_flag, 0);
    chk("R5", "irq after error clear", irq, 0);
    err_ie = 0;

    // Launch a wipe
    inv_launch = 1; step(); inv_launch = 0;
    chk("R10", "inv_rd after launch", inv_rd, 1);
    chk("R1", "busy one cycle after launch", busy, 0);
    chk("R3", "bypass while pending", bypass, 1);
    look(2, tag_of(2, 0));
    chk("R3", "no hit while pending", lookup_hit, 0);
    step();
    chk("R1", "busy after start", busy, 1);
    chk("R10", "inv_rd self-clears", inv_rd, 0);
    chk("R3", "bypass while busy", bypass, 1);
    count_busy(n);  // launch strobe injected mid-sweep
    chk("R1", "busy cycle count", n, SETS);
    chk("R4", "busyend set at end", busyend, 1);
    chk("R10", "no launch captured during sweep", inv_rd, 0);
    step();
    chk("R10", "no second sweep", busy, 0);

    // All lines invalid after the wipe
    for (int i = 0; i < SETS; i++)
      for (int w = 0; w < 2; w++) begin
        look(i, tag_of(i, w));
        chk("R9", $sformatf("miss after wipe idx%0d way%0d", i, w), lookup_hit, 0);
      end

    // Completion interrupt and clear
    chk("R5", "irq masked busyend", irq, 0);
    busyend_ie = 1; #1;
    chk("R5", "irq from busyend", irq, 1);
    repeat (4) step();
    chk("R4", "busyend sticky", busyend, 1);
    clr_busyend = 1; step(); clr_busyend = 0;
    chk("R4", "busyend cleared", busyend, 0);
    chk("R5", "irq after busyend clear", irq, 0);

    // Disable starts a wipe
    fill(5, 1, tag_of(5, 1));
    en_wr = 1; en_wdata = 0; step(); en_wr = 0;
    chk("R2", "en_rd still 1 after disable write", en_rd, 1);
    chk("R2", "busy not yet", busy, 0);
    chk("R3", "bypass while disable pending", bypass, 1);
    step();
    chk("R2", "en_rd falls at start", en_rd, 0);
    chk("R2", "busy from disable", busy, 1);
    count_busy(n);
    chk("R2", "disable sweep length", n, SETS);
    chk("R4", "busyend after disable sweep", busyend, 1);

    // Direct-mapped mode
    assoc_wr = 1; assoc_wdata = 0; step(); assoc_wr = 0;
    chk("R7", "assoc write while disabled", assoc_rd, 0);
    en_wr = 1; en_wdata = 1; step(); en_wr = 0;
    look(5, tag_of(5, 1));
    chk("R9", "line from before disable gone", lookup_hit, 0);
    fill(2, 1, 4'd9);
    look(2, 4'd9);
    chk("R8", "direct fill hits", lookup_hit, 1);
    chk("R8", "direct fill lands in way0", hit_way, 0);
    fill(2, 0, 4'd5);
    look(2, 4'd9);
    chk("R8", "way0 overwritten in direct mode", lookup_hit, 0);
    look(2, 4'd5);
    chk("R8", "new way0 tag hits", lookup_hit, 1);

    finish_up();
  end

endmodule